// File: doc/BRIEF.md
# Quadrature Four-Phase Clock Generator

This block divides one input clock, running at four times the wanted local-oscillator rate, into an in-phase clock and a quadrature clock that trails it by a quarter period. It also produces a one-hot bus of four registered phase enables. Each enable drives one switch of a commutating mixer, so at any moment exactly one switch is closed.

The core is a twisted ring of flip-flops that all share the same rising edge of the input clock. No stage output clocks another stage, so the outputs are not skewed by a ripple chain. The falling edge is never used, so the duty cycle of the input clock does not affect the outputs. Each output is high for two input cycles and low for two. An enable input freezes the ring and the phase bus, and a synchronous active-low reset puts everything into a known starting state.

Top module: `quad_clock_gen`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, the next outputs are `i_clk_o`=0, `q_clk_o`=0 and `phase_o`=4'b0001, regardless of `en`.
- R2: With `en` high and `rst_n` high, each rising edge advances (`i_clk_o`,`q_clk_o`) one step through the order 00, 10, 11, 01, and then back to 00.
- R3: `phase_o` bit 0 is high for state (I,Q)=00, bit 1 for 10, bit 2 for 11 and bit 3 for 01. This holds on the same cycle as the state.
- R4: After reset, exactly one bit of `phase_o` is high on every cycle.
- R5: While enabled, each of `i_clk_o` and `q_clk_o` holds each level for exactly two consecutive enabled edges (a 50% duty cycle at one quarter of the input rate).
- R6: After an enabled edge, `q_clk_o` equals the value that `i_clk_o` had before that edge, so Q trails I by a quarter of the output period.
- R7: While `en` is low, `i_clk_o`, `q_clk_o` and `phase_o` hold their values. When `en` returns high, the sequence continues from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at four times the output rate; only its rising edge is used |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low freezes all outputs |
| i_clk_o | output | 1 | In-phase output clock |
| q_clk_o | output | 1 | Quadrature output clock, trailing I by 90 degrees |
| phase_o | output | 4 | One-hot registered switch enables, phases 0 to 3 |

## Verification
The hardest case to reach is a pause or a reset that lands at each of the four ring positions. The resumed sequence and the run-length of each output must still be correct afterwards. The stimulus drives `en` from a seeded random stream that is low about a quarter of the time, so pauses fall on every state and come in many lengths. It also injects occasional random resets, plus directed cases: a long pause in state 11 and a reset in state 01. The bench model tracks the expected state and the run length of each output across these interruptions.

// File: rtl/quad_pkg.sv
// Package: shared constants and helpers for the quadrature clock generator.
// Assumes the ring has an even number of stages so that a quarter-period
// tap exists.
package quad_pkg;

    // Default number of twisted-ring stages (two stages give four phases).
    localparam int QUAD_DEFAULT_STAGES = 2;

    // Number of distinct ring states, and so of one-hot phases, for a ring.
    function automatic int ring_states(input int stages);
        return 2 * stages;
    endfunction

endpackage

// File: rtl/quad_ring_core.sv
// Module: quad_ring_core
// Twisted (Johnson) ring of STAGES flip-flops. All of them are clocked on
// the same rising edge. Stage 0 loads the inverse of the last stage, and
// every other stage loads its predecessor. The module also exposes the
// next-state vector so that a decoder can register its outputs in step
// with the ring.
// Assumes: STAGES is even and at least 2; synchronous active-low reset.
module quad_ring_core #(
    parameter int STAGES = quad_pkg::QUAD_DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [STAGES-1:0] ring_q,
    output logic [STAGES-1:0] ring_d
);

    // Next-state shift: the inverted tail wraps around to the head.
    always_comb begin
        ring_d[0] = ~ring_q[STAGES-1];
        for (int s = 1; s < STAGES; s++) begin
            ring_d[s] = ring_q[s-1];
        end
    end

    // State register: clear on reset, advance on enable, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else if (en) begin
            ring_q <= ring_d;
        end
    end

endmodule

// File: rtl/quad_phase_decoder.sv
// Module: quad_phase_decoder
// Registered decoder that maps each ring state onto one one-hot phase bit.
// It decodes the ring's next state and loads the result on the same edge
// as the ring, so the phase register always matches the ring register.
// Because the outputs come straight from flip-flops, they carry no
// decode glitches.
// Assumes: the ring only visits legal twisted-ring states.
module quad_phase_decoder #(
    parameter int STAGES = quad_pkg::QUAD_DEFAULT_STAGES,
    localparam int PHASES = quad_pkg::ring_states(STAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [STAGES-1:0] ring_next,
    output logic [PHASES-1:0] phase_q
);

    // Ring pattern for step k: ones fill in from stage 0, then zeros follow.
    function automatic logic [STAGES-1:0] pattern_of(input int k);
        logic [STAGES-1:0] p;
        for (int b = 0; b < STAGES; b++) begin
            if (k < STAGES) p[b] = (b < k);
            else            p[b] = (b >= k - STAGES);
        end
        return p;
    endfunction

    logic [PHASES-1:0] phase_d;

    // Compare the next state against every legal pattern.
    always_comb begin
        for (int k = 0; k < PHASES; k++) begin
            phase_d[k] = (ring_next == pattern_of(k));
        end
    end

    // Phase register: phase 0 on reset, follow the ring on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= '0;
            phase_q[0] <= 1'b1;
        end else if (en) begin
            phase_q <= phase_d;
        end
    end

    // R4: the registered phase bus is one-hot on every cycle out of reset.
    assert_phase_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(phase_q));

    // R2: an enabled edge moves the active phase up by one, wrapping around.
    assert_phase_rotates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> phase_q == {$past(phase_q[PHASES-2:0]), $past(phase_q[PHASES-1])});

endmodule

// File: rtl/quad_clock_gen.sv
// Module: quad_clock_gen
// Top level of the quadrature clock generator. It takes I from ring stage
// 0 and Q from the stage half-way round the ring, which lags by a quarter
// period. It also provides the registered one-hot phase enables for a
// commutating mixer.
// Assumes: clk runs at four times the output rate (with the default
// stages); only the rising edge of clk is used.
module quad_clock_gen #(
    parameter int STAGES = quad_pkg::QUAD_DEFAULT_STAGES,
    localparam int PHASES = quad_pkg::ring_states(STAGES),
    localparam int Q_TAP = STAGES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic              i_clk_o,
    output logic              q_clk_o,
    output logic [PHASES-1:0] phase_o
);

    logic [STAGES-1:0] ring_q;
    logic [STAGES-1:0] ring_d;

    quad_ring_core #(.STAGES(STAGES)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .ring_q (ring_q),
        .ring_d (ring_d)
    );

    quad_phase_decoder #(.STAGES(STAGES)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ring_next (ring_d),
        .phase_q   (phase_o)
    );

    // Output taps: I from the head stage, Q from the quarter-period stage.
    always_comb begin
        i_clk_o = ring_q[0];
        q_clk_o = ring_q[Q_TAP];
    end

    // R1: a reset edge leaves both clocks low and phase 0 active.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!i_clk_o && !q_clk_o && phase_o == PHASES'(1)));

    // R3: phase 0 is active exactly when both clocks are low.
    assert_phase0_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o[0] == (!i_clk_o && !q_clk_o));

    // R7: with the enable low, clocks and phases keep their values.
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable({i_clk_o, q_clk_o, phase_o}));

endmodule

// File: tb/quad_clock_gen_bench.sv
module quad_clock_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       i_clk_o;
    logic       q_clk_o;
    logic [3:0] phase_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // model state
    int  k = 0;
    bit  prev_i = 0, prev_q = 0;
    int  run_i = 0, run_q = 0;
    bit  seen_i = 0, seen_q = 0;

    always #2 clk = ~clk;   // 250 MHz

    quad_clock_gen u_quad_clock_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .i_clk_o (i_clk_o),
        .q_clk_o (q_clk_o),
        .phase_o (phase_o)
    );

    function automatic bit exp_i(input int s); return (s == 1) || (s == 2); endfunction
    function automatic bit exp_q(input int s); return (s == 2) || (s == 3); endfunction
    function automatic logic [3:0] exp_ph(input int s); return 4'b0001 << s; endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Apply inputs at the falling edge, update the model at the rising edge
    // and check 1 ns later.
    task automatic step(input bit e, input bit r);
        bit i_before;
        @(negedge clk);
        en = e;
        rst_n = r;
        i_before = i_clk_o;
        @(posedge clk);
        if (!r) begin
            k = 0; run_i = 0; run_q = 0; seen_i = 0; seen_q = 0;
        end else if (e) begin
            k = (k + 1) % 4;
        end
        #1;
        if (!r) begin
            check(i_clk_o == 0 && q_clk_o == 0 && phase_o == 4'b0001, "R1",
                  {i_clk_o, q_clk_o, phase_o}, 6'b000001);
        end else begin
            check({i_clk_o, q_clk_o} == {exp_i(k), exp_q(k)}, e ? "R2" : "R7",
                  {i_clk_o, q_clk_o}, {exp_i(k), exp_q(k)});
            check(phase_o == exp_ph(k), "R3", phase_o, exp_ph(k));
            check($countones(phase_o) == 1, "R4", phase_o, exp_ph(k));
            if (e) begin
                check(q_clk_o == i_before, "R6", q_clk_o, i_before);
                // R5 run-length tracking over enabled edges
                if (i_clk_o != prev_i) begin
                    if (seen_i) check(run_i == 2, "R5 I", run_i, 2);
                    seen_i = 1; run_i = 1;
                end else run_i++;
                if (q_clk_o != prev_q) begin
                    if (seen_q) check(run_q == 2, "R5 Q", run_q, 2);
                    seen_q = 1; run_q = 1;
                end else run_q++;
            end
        end
        prev_i = i_clk_o;
        prev_q = q_clk_o;
    endtask

    initial begin
        void'($urandom(32'd4021));
        // reset
        for (int c = 0; c < 4; c++) step(1'b1, 1'b0);
        // R2/R5/R6: long free run
        for (int c = 0; c < 40; c++) step(1'b1, 1'b1);
        // R7: advance to state 11 then hold a long pause
        while (k != 2) step(1'b1, 1'b1);
        for (int c = 0; c < 10; c++) step(1'b0, 1'b1);
        for (int c = 0; c < 8; c++) step(1'b1, 1'b1);
        // R1: reset from state 01 with enable high
        while (k != 3) step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // random stretch
        for (int c = 0; c < 3000; c++) begin
            bit e = (($urandom % 4) != 0);
            bit r = (($urandom % 97) != 0);
            step(e, r);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule